// File: doc/BRIEF.md
# FIFO Ticket-and-Flag Lock Manager

The block arbitrates one shared resource among a fixed set of requesters and grants it strictly in the order the requests were taken. It holds a ticket counter and a ring of per-slot ownership flags. When a requester raises its acquire strobe, it is given the current counter value truncated to the slot width as its slot, and the counter advances. That requester then owns the resource exactly while the flag of its own slot is set.

When the owner strobes release, its slot flag is cleared and the flag of the following slot (wrapping at the ring size) is set. The lock therefore passes straight to the next queued requester. No waiter looks at any flag but its own.

Acquires that arrive in the same cycle are ordered by requester index, lowest first. A release from anyone but the current owner changes nothing and pulses an error output.

Top module: `qlock_unit`

## Requirements
- R1: After synchronous reset, no grant is asserted, `err_o` is 0, the ticket counter is 0 and only slot 0 owns the lock. The first acquirer after reset therefore receives slot 0.
- R2: An acquire from an idle requester takes the counter value modulo NUM_REQ as its slot. The slot appears on that requester's field of `slot_o` (bits [i*IDXW +: IDXW]) one cycle after the strobe, and the counter advances by one.
- R3: Acquires arriving in the same cycle receive consecutive slots, with the lowest requester index taking the lowest slot.
- R4: `grant_o[i]` is 1 exactly when requester i is queued and the flag of its slot is set. An acquirer whose slot already owns the lock is granted one cycle after its strobe.
- R5: At most one bit of `grant_o` is 1 in any cycle.
- R6: A release from the owner clears its grant one cycle later. In the same cycle, the requester holding slot (slot+1) mod NUM_REQ is granted if it is queued.
- R7: Grants follow the order in which acquires were taken, and this order holds across wrap-around of the counter.
- R8: A release from a requester that is not the owner leaves every grant and slot unchanged, and `err_o` is 1 in the following cycle. In every other cycle `err_o` is 0.
- R9: An acquire from a requester that is already queued is ignored: its slot is unchanged and the counter does not advance.
- R10: A queued requester's slot stays constant from its acquire until its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_i | input | NUM_REQ | Per-requester acquire strobe |
| rel_i | input | NUM_REQ | Per-requester release strobe |
| grant_o | output | NUM_REQ | Per-requester ownership |
| slot_o | output | NUM_REQ*IDXW | Assigned slot per requester, field i at [i*IDXW +: IDXW] |
| err_o | output | 1 | Pulses one cycle after a release from a non-owner |

## Verification
The bench uses the default NUM_REQ of 4, which gives a two-bit slot field. With only four slots, the counter wraps every few acquires, so hand-off from slot 3 back to slot 0 comes up again and again. The small ring also makes a completely full queue, with all requesters waiting, a common state under random strobes. This in turn lets same-cycle acquires, re-acquires by queued requesters and bad releases by waiters all land at arbitrary queue positions.

// File: rtl/qlock_pkg.sv
package qlock_pkg;

    typedef enum logic {
        MUST_WAIT = 1'b0,
        HAS_LOCK  = 1'b1
    } flag_e;

    localparam int unsigned MAX_REQ = 32;

    function automatic int unsigned slot_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/qlock_ticket.sv
module qlock_ticket
    import qlock_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IDXW = slot_bits(NUM_REQ)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_REQ-1:0]             take_i,
    output logic [NUM_REQ-1:0][IDXW-1:0]   place_o
);
    logic [IDXW-1:0] cnt_q;
    logic [IDXW-1:0] cnt_d;

    always_comb begin
        logic [IDXW-1:0] run;
        run = cnt_q;
        for (int i = 0; i < NUM_REQ; i++) begin
            place_o[i] = run;
            if (take_i[i]) run = run + 1'b1;
        end
        cnt_d = run;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R9: no take means the counter holds
    a_r9_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (take_i == '0) |=> $stable(cnt_q));

    // R2: a single take advances by exactly one
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
        ($countones(take_i) == 1) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/qlock_flags.sv
module qlock_flags
    import qlock_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IDXW = slot_bits(NUM_REQ)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pass_i,
    input  logic [IDXW-1:0]      pass_slot_i,
    output logic [NUM_REQ-1:0]   own_o
);
    flag_e           ring_q [NUM_REQ];
    logic [IDXW-1:0] next_slot;

    assign next_slot = pass_slot_i + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_REQ; s++)
                ring_q[s] <= (s == 0) ? HAS_LOCK : MUST_WAIT;
        end else if (pass_i) begin
            ring_q[pass_slot_i] <= MUST_WAIT;
            ring_q[next_slot]   <= HAS_LOCK;
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_REQ; s++)
            own_o[s] = (ring_q[s] == HAS_LOCK);
    end

    // R4: exactly one slot owns the lock
    a_r4_one_owner: assert property (@(posedge clk) disable iff (rst)
        $onehot(own_o));

    // R8: no valid pass leaves the ring untouched
    a_r8_ring_hold: assert property (@(posedge clk) disable iff (rst)
        !pass_i |=> $stable(own_o));

    // R6: ownership moves to the following slot
    a_r6_handoff: assert property (@(posedge clk) disable iff (rst)
        pass_i |=> own_o[$past(next_slot)]);

endmodule

// File: rtl/qlock_requester.sv
module qlock_requester
    import qlock_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IDXW = slot_bits(NUM_REQ)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acq_i,
    input  logic                 rel_i,
    input  logic [IDXW-1:0]      place_i,
    input  logic [NUM_REQ-1:0]   own_i,
    output logic                 take_o,
    output logic                 hold_o,
    output logic                 rel_ok_o,
    output logic                 rel_bad_o,
    output logic [IDXW-1:0]      slot_o
);
    typedef struct packed {
        logic            queued;
        logic [IDXW-1:0] slot;
    } seat_t;

    seat_t seat_q;

    assign take_o    = acq_i && !seat_q.queued;
    assign hold_o    = seat_q.queued && own_i[seat_q.slot];
    assign rel_ok_o  = rel_i && hold_o;
    assign rel_bad_o = rel_i && !hold_o;
    assign slot_o    = seat_q.slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            seat_q <= '0;
        end else if (take_o) begin
            seat_q.queued <= 1'b1;
            seat_q.slot   <= place_i;
        end else if (rel_ok_o) begin
            seat_q.queued <= 1'b0;
        end
    end

    // R10: slot frozen while queued and not released
    a_r10_slot_stable: assert property (@(posedge clk) disable iff (rst)
        (seat_q.queued && !rel_ok_o) |=> $stable(slot_o));

    // R6: owner leaves the queue after release
    a_r6_leave: assert property (@(posedge clk) disable iff (rst)
        rel_ok_o |=> !hold_o);

endmodule

// File: rtl/qlock_unit.sv
module qlock_unit
    import qlock_pkg::*;
#(
    parameter int unsigned NUM_REQ = 4,
    localparam int unsigned IDXW = slot_bits(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_REQ-1:0]        acq_i,
    input  logic [NUM_REQ-1:0]        rel_i,
    output logic [NUM_REQ-1:0]        grant_o,
    output logic [NUM_REQ*IDXW-1:0]   slot_o,
    output logic                      err_o
);
    logic [NUM_REQ-1:0]            take;
    logic [NUM_REQ-1:0]            rel_ok;
    logic [NUM_REQ-1:0]            rel_bad;
    logic [NUM_REQ-1:0]            own;
    logic [NUM_REQ-1:0][IDXW-1:0]  place;
    logic [NUM_REQ-1:0][IDXW-1:0]  slot;
    logic                          pass;
    logic [IDXW-1:0]               pass_slot;
    logic                          err_q;

    initial begin
        assert (NUM_REQ >= 2 && NUM_REQ <= MAX_REQ && (NUM_REQ & (NUM_REQ - 1)) == 0)
            else $error("NUM_REQ must be a power of two in range");
    end

    qlock_ticket #(.NUM_REQ(NUM_REQ)) u_ticket (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .place_o (place)
    );

    qlock_flags #(.NUM_REQ(NUM_REQ)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .pass_i      (pass),
        .pass_slot_i (pass_slot),
        .own_o       (own)
    );

    for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
        qlock_requester #(.NUM_REQ(NUM_REQ)) u_req (
            .clk       (clk),
            .rst       (rst),
            .acq_i     (acq_i[i]),
            .rel_i     (rel_i[i]),
            .place_i   (place[i]),
            .own_i     (own),
            .take_o    (take[i]),
            .hold_o    (grant_o[i]),
            .rel_ok_o  (rel_ok[i]),
            .rel_bad_o (rel_bad[i]),
            .slot_o    (slot[i])
        );
        assign slot_o[i*IDXW +: IDXW] = slot[i];
    end

    always_comb begin
        pass_slot = '0;
        for (int i = 0; i < NUM_REQ; i++)
            if (rel_ok[i]) pass_slot = pass_slot | slot[i];
    end

    assign pass = |rel_ok;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= |rel_bad;
    end

    assign err_o = err_q;

    // R5: mutual exclusion on the grants
    a_r5_mutex: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R8: a release by a non-owner raises the error next cycle
    a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
        ((rel_i & ~grant_o) != '0) |=> err_o);

    // R8: grants unchanged when no owner releases
    a_r8_grant_keep: assert property (@(posedge clk) disable iff (rst)
        ((rel_i & grant_o) == '0) |=> ((grant_o & $past(grant_o)) == $past(grant_o)));

endmodule

// File: tb/qlock_unit_tb.sv
module qlock_unit_tb;
    localparam int P = 4;
    localparam int W = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [P-1:0]   acq_i = '0;
    logic [P-1:0]   rel_i = '0;
    logic [P-1:0]   grant_o;
    logic [P*W-1:0] slot_o;
    logic           err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit mq [P];
    int ms [P];
    bit mf [P];
    int mc;
    bit merr;

    always #2 clk = ~clk;

    qlock_unit #(.NUM_REQ(P)) u_dut (
        .clk(clk), .rst(rst), .acq_i(acq_i), .rel_i(rel_i),
        .grant_o(grant_o), .slot_o(slot_o), .err_o(err_o)
    );

    function automatic bit holds(int i);
        return mq[i] && mf[ms[i]];
    endfunction

    function automatic logic [P-1:0] exp_grant();
        logic [P-1:0] g;
        for (int i = 0; i < P; i++) g[i] = holds(i);
        return g;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < P; i++) begin
            mq[i] = 0; ms[i] = 0; mf[i] = (i == 0);
        end
        mc = 0; merr = 0;
    endtask

    task automatic model_step(logic [P-1:0] a, logic [P-1:0] r);
        bit ok [P];
        bit bad;
        int offs;
        bad = 0;
        for (int i = 0; i < P; i++) begin
            ok[i] = r[i] && holds(i);
            if (r[i] && !ok[i]) bad = 1;
        end
        for (int i = 0; i < P; i++) begin
            if (ok[i]) begin
                mf[ms[i]] = 0;
                mf[(ms[i] + 1) % P] = 1;
                mq[i] = 0;
            end
        end
        offs = 0;
        for (int i = 0; i < P; i++) begin
            if (a[i] && !mq[i] && !ok[i]) begin
                ms[i] = (mc + offs) % P;
                mq[i] = 1;
                offs++;
            end
        end
        mc = (mc + offs) % P;
        merr = bad;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(logic [P-1:0] a, logic [P-1:0] r, string tag);
        @(negedge clk);
        acq_i = a; rel_i = r;
        model_step(a, r);
        @(posedge clk);
        #1;
        acq_i = '0; rel_i = '0;
        check(tag, "grant", int'(grant_o), int'(exp_grant()));
        check(tag, "err", int'(err_o), int'(merr));
        for (int i = 0; i < P; i++)
            if (mq[i]) check(tag, $sformatf("slot%0d", i), int'(slot_o[i*W +: W]), ms[i]);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "grant", int'(grant_o), 0);
        check("R1", "err", int'(err_o), 0);
        // R1 R2 R4: first acquirer takes slot 0 and is granted
        step(4'b0100, '0, "R1 R2 R4");
        check("R4", "grant2", int'(grant_o[2]), 1);
        // R3: same-cycle acquires, lowest index first
        step(4'b1011, '0, "R3");
        check("R3", "slot0", int'(slot_o[0 +: W]), 1);
        check("R3", "slot3", int'(slot_o[3*W +: W]), 3);
        // R9: re-acquire while queued is ignored
        step(4'b0001, '0, "R9");
        check("R9", "slot0", int'(slot_o[0 +: W]), 1);
        // R8: release by a waiter is ignored, error pulses
        step('0, 4'b0010, "R8");
        check("R8", "err", int'(err_o), 1);
        check("R8", "grant", int'(grant_o), 4'b0100);
        step('0, '0, "R8");
        check("R8", "err clear", int'(err_o), 0);
        // R6: owner releases, next slot granted
        step('0, 4'b0100, "R6");
        check("R6", "grant", int'(grant_o), 4'b0001);
        // R7: re-acquire wraps to slot 0, served after slots 2 and 3
        step(4'b0100, '0, "R7");
        check("R7", "slot2", int'(slot_o[2*W +: W]), 0);
        step('0, 4'b0001, "R7");
        check("R7", "grant", int'(grant_o), 4'b0010);
        step('0, 4'b0010, "R7");
        check("R7", "grant", int'(grant_o), 4'b1000);
        step('0, 4'b1000, "R7 R10");
        check("R7", "grant", int'(grant_o), 4'b0100);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [P-1:0] a;
            logic [P-1:0] r;
            a = P'($urandom) & P'($urandom);
            r = '0;
            if ($urandom_range(2) == 0) r = exp_grant();
            if ($urandom_range(7) == 0) r[$urandom_range(P-1)] = 1'b1;
            step(a, r, "R2 R4 R5 R6 R7 R8 R10");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule